// File: doc/BRIEF.md
# Boot Lock and Debug Access Gate

This block is the security control unit of an embedded flash controller. It holds three bits: a boot-lock bit that forces the system to start from main flash, a software debug-enable bit, and a sticky bit that marks the securable memory area as locked. The current readout-protection level comes in as an input. From these the block drives a debug-allowed signal, a forced-main-flash boot signal and a securable-area-locked signal. Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Setting the boot lock is always accepted. Clearing it depends on the protection level. At level 0 a clear takes effect at once. At level 1 a clear is accepted only when the same operation also asks for a return to level 0. In that case the block raises a mass-erase request and waits for the erase-complete handshake. The lock drops only when the erase completes. If the erase does not complete in time, or the clear is not allowed at the current level, the block leaves the lock unchanged and gives a one-cycle reject pulse. At level 2 the debug path is held off in hardware.

Top module: `bootlock_debug_gate`

## Requirements
- R1: When `prot_lvl` is 2, `dbg_allow` is 0 after the next edge, whatever the software debug-enable bit holds.
- R2: At any level other than 2, `dbg_allow` equals the software debug-enable bit. The bit resets to 1, 1 allows debug, and a write (`dbg_wr` with `dbg_wr_val`) takes effect at the same edge as the output.
- R3: A `prot_lvl` code of 3 behaves exactly like level 1, both for debug and for clear qualification.
- R4: `boot_force_main` equals the boot-lock bit. A `lock_set_req` sets it at any level, and it stays set until a clear is accepted.
- R5: At level 0, from the idle state, `lock_clr_req` clears the lock at the next edge, with no reject pulse.
- R6: At level 1 with `lvl0_req` high, a clear raises `erase_req` at the next edge. The lock stays set until the edge that samples `erase_done`. At that edge the lock clears and `erase_req` drops.
- R7: A clear at level 2, or at level 1 without `lvl0_req`, leaves the lock unchanged and gives `clr_reject` high for exactly one cycle. A clear request received while an erase is pending is ignored.
- R8: If `erase_done` has not arrived within ERASE_TMO cycles of `erase_req` rising, the pending clear is dropped: `erase_req` falls, `clr_reject` pulses and the lock stays unchanged.
- R9: A set request wins over a clear. If it arrives together with a clear request, or while an erase is pending (even in the same cycle as `erase_done`), the lock ends up set, any pending clear is cancelled and `clr_reject` pulses.
- R10: `sec_set` sets `sec_locked` at the next edge. Only reset returns it to 0.
- R11: While `rst` is high, every output is 0 at each edge and the debug-enable bit returns to 1. The boot lock returns to LOCK_INIT, whose default is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_lvl | input | 2 | Readout-protection level: 0, 1, 2, and 3 taken as 1 |
| lvl0_req | input | 1 | The clear operation also requests a return to level 0 |
| lock_set_req | input | 1 | Request to set the boot lock (one cycle) |
| lock_clr_req | input | 1 | Request to clear the boot lock (one cycle) |
| erase_done | input | 1 | Full mass erase finished |
| dbg_wr | input | 1 | Write strobe for the debug-enable bit |
| dbg_wr_val | input | 1 | Value written to the debug-enable bit |
| sec_set | input | 1 | Lock the securable area (sticky) |
| dbg_allow | output | 1 | Debug access permitted |
| boot_force_main | output | 1 | Boot from main flash regardless of other boot selection |
| sec_locked | output | 1 | Securable area is locked |
| clr_reject | output | 1 | One-cycle pulse: a clear was refused or dropped |
| erase_req | output | 1 | Mass erase requested for a pending clear |

## Verification
Two functions can fall in the same cycle: a set request and the erase completion that finishes a pending level-1 clear. The bench provokes this by starting a qualified clear at level 1 and then raising `lock_set_req` and `erase_done` in the same cycle. The expected result, derived from R9, is the lock set, `erase_req` low and one reject pulse. The bench also applies simultaneous set and clear requests from idle at level 0, where an accepted clear would otherwise win. An independent cycle model in the bench predicts every output at each edge, and a monitor compares those predictions in order.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_GUARD = 2'd1,
    LVL_SEAL  = 2'd2
  } eff_lvl_t;

  typedef enum logic {
    CLR_IDLE = 1'b0,
    CLR_WAIT = 1'b1
  } clr_state_t;

  typedef struct packed {
    logic set_req;
    logic clr_req;
    logic lvl0_req;
    logic erase_done;
  } lock_cmd_t;

endpackage

// File: rtl/bootlock_lvl_decode.sv
module bootlock_lvl_decode
  import bootlock_pkg::*;
#(
  parameter eff_lvl_t CODE3_AS = LVL_GUARD
) (
  input  logic [1:0] raw_lvl,
  output eff_lvl_t   eff_lvl,
  output logic       is_open,
  output logic       is_guard,
  output logic       is_seal
);
  always_comb begin
    unique case (raw_lvl)
      2'd0:    eff_lvl = LVL_OPEN;
      2'd1:    eff_lvl = LVL_GUARD;
      2'd2:    eff_lvl = LVL_SEAL;
      default: eff_lvl = CODE3_AS;
    endcase
  end

  assign is_open  = (eff_lvl == LVL_OPEN);
  assign is_guard = (eff_lvl == LVL_GUARD);
  assign is_seal  = (eff_lvl == LVL_SEAL);
endmodule

// File: rtl/bootlock_lock_ctrl.sv
module bootlock_lock_ctrl
  import bootlock_pkg::*;
#(
  parameter int   ERASE_TMO = 1000,
  parameter logic LOCK_INIT = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  lock_cmd_t cmd,
  input  logic      is_open,
  input  logic      is_guard,
  output logic      lock_q,
  output logic      reject_q,
  output logic      erase_req_q
);
  localparam int TW = $clog2(ERASE_TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(ERASE_TMO - 1);

  clr_state_t st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic lock_d, reject_d;

  always_comb begin
    st_d     = st_q;
    lock_d   = lock_q;
    reject_d = 1'b0;
    tmr_d    = (st_q == CLR_WAIT) ? tmr_q + 1'b1 : '0;
    unique case (st_q)
      CLR_IDLE: begin
        if (cmd.set_req) begin
          lock_d   = 1'b1;
          reject_d = cmd.clr_req;
        end else if (cmd.clr_req) begin
          if (is_open) begin
            lock_d = 1'b0;
          end else if (is_guard && cmd.lvl0_req) begin
            st_d  = CLR_WAIT;
            tmr_d = '0;
          end else begin
            reject_d = 1'b1;
          end
        end
      end
      CLR_WAIT: begin
        if (cmd.set_req) begin
          lock_d   = 1'b1;
          st_d     = CLR_IDLE;
          reject_d = 1'b1;
        end else if (cmd.erase_done) begin
          lock_d = 1'b0;
          st_d   = CLR_IDLE;
        end else if (tmr_q == TMO_LAST) begin
          reject_d = 1'b1;
          st_d     = CLR_IDLE;
        end
      end
      default: st_d = CLR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CLR_IDLE;
      tmr_q       <= '0;
      lock_q      <= LOCK_INIT;
      reject_q    <= 1'b0;
      erase_req_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      tmr_q       <= tmr_d;
      lock_q      <= lock_d;
      reject_q    <= reject_d;
      erase_req_q <= (st_d == CLR_WAIT);
    end
  end
endmodule

// File: rtl/bootlock_dbg_gate.sv
module bootlock_dbg_gate #(
  parameter logic DBG_EN_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic is_seal,
  input  logic dbg_wr,
  input  logic dbg_wr_val,
  input  logic sec_set,
  output logic dbg_allow_q,
  output logic sec_q
);
  logic sw_en_q, sw_en_d;

  assign sw_en_d = dbg_wr ? dbg_wr_val : sw_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en_q     <= DBG_EN_INIT;
      sec_q       <= 1'b0;
      dbg_allow_q <= 1'b0;
    end else begin
      sw_en_q     <= sw_en_d;
      sec_q       <= sec_q | sec_set;
      dbg_allow_q <= sw_en_d & ~is_seal;
    end
  end
endmodule

// File: rtl/bootlock_debug_gate.sv
module bootlock_debug_gate
  import bootlock_pkg::*;
#(
  parameter int   ERASE_TMO = 1000,
  parameter logic LOCK_INIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] prot_lvl,
  input  logic       lvl0_req,
  input  logic       lock_set_req,
  input  logic       lock_clr_req,
  input  logic       erase_done,
  input  logic       dbg_wr,
  input  logic       dbg_wr_val,
  input  logic       sec_set,
  output logic       dbg_allow,
  output logic       boot_force_main,
  output logic       sec_locked,
  output logic       clr_reject,
  output logic       erase_req
);
  eff_lvl_t  eff_lvl;
  logic      is_open, is_guard, is_seal;
  lock_cmd_t cmd;

  assign cmd = '{set_req: lock_set_req, clr_req: lock_clr_req,
                 lvl0_req: lvl0_req, erase_done: erase_done};

  bootlock_lvl_decode #(.CODE3_AS(LVL_GUARD)) u_lvl (
    .raw_lvl (prot_lvl),
    .eff_lvl (eff_lvl),
    .is_open (is_open),
    .is_guard(is_guard),
    .is_seal (is_seal)
  );

  bootlock_lock_ctrl #(.ERASE_TMO(ERASE_TMO), .LOCK_INIT(LOCK_INIT)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .is_open    (is_open),
    .is_guard   (is_guard),
    .lock_q     (boot_force_main),
    .reject_q   (clr_reject),
    .erase_req_q(erase_req)
  );

  bootlock_dbg_gate #(.DBG_EN_INIT(1'b1)) u_dbg (
    .clk        (clk),
    .rst        (rst),
    .is_seal    (is_seal),
    .dbg_wr     (dbg_wr),
    .dbg_wr_val (dbg_wr_val),
    .sec_set    (sec_set),
    .dbg_allow_q(dbg_allow),
    .sec_q      (sec_locked)
  );
endmodule

// File: rtl/bootlock_debug_gate_chk.sv
module bootlock_debug_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] prot_lvl,
  input logic       lock_set_req,
  input logic       erase_done,
  input logic       sec_set,
  input logic       dbg_allow,
  input logic       boot_force_main,
  input logic       sec_locked,
  input logic       clr_reject
);
  AST_SEAL_NO_DEBUG: assert property (@(posedge clk) disable iff (rst)
    prot_lvl == 2'd2 |=> !dbg_allow); // R1

  AST_SET_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
    lock_set_req |=> boot_force_main); // R4

  AST_LOCK_FALL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_force_main) |-> ($past(erase_done) || $past(prot_lvl) == 2'd0)); // R6

  AST_NO_REJECT_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_force_main) |-> !clr_reject); // R7

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (rst)
    sec_locked |=> sec_locked); // R10

  AST_SEC_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    sec_set |=> sec_locked); // R10
endmodule

bind bootlock_debug_gate bootlock_debug_gate_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .prot_lvl       (prot_lvl),
  .lock_set_req   (lock_set_req),
  .erase_done     (erase_done),
  .sec_set        (sec_set),
  .dbg_allow      (dbg_allow),
  .boot_force_main(boot_force_main),
  .sec_locked     (sec_locked),
  .clr_reject     (clr_reject)
);

// File: tb/test_bootlock_debug_gate.sv
`timescale 1ns/1ps
module test_bootlock_debug_gate;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] prot_lvl = 2'd0;
  logic lvl0_req = 0, lock_set_req = 0, lock_clr_req = 0, erase_done = 0;
  logic dbg_wr = 0, dbg_wr_val = 0, sec_set = 0;
  logic dbg_allow, boot_force_main, sec_locked, clr_reject, erase_req;

  always #2.5 clk = ~clk;

  bootlock_debug_gate #(.ERASE_TMO(TMO), .LOCK_INIT(1'b0)) i_bootlock_debug_gate (
    .clk(clk), .rst(rst), .prot_lvl(prot_lvl), .lvl0_req(lvl0_req),
    .lock_set_req(lock_set_req), .lock_clr_req(lock_clr_req),
    .erase_done(erase_done), .dbg_wr(dbg_wr), .dbg_wr_val(dbg_wr_val),
    .sec_set(sec_set), .dbg_allow(dbg_allow), .boot_force_main(boot_force_main),
    .sec_locked(sec_locked), .clr_reject(clr_reject), .erase_req(erase_req)
  );

  typedef struct {
    string tag;
    logic [4:0] exp; // {dbg_allow, boot, sec, reject, erase_req}
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic m_lock = 0, m_sw = 1, m_sec = 0, m_wait = 0;
  int m_tmr = 0;
  logic [4:0] m_next;

  // computes the outputs expected after the coming edge and updates the model
  task automatic step(string tag);
    item_t it;
    logic [1:0] eff;
    logic rej, nlock, nwait, nsw, nsec;
    int ntmr;
    eff = (prot_lvl == 2'd3) ? 2'd1 : prot_lvl;
    if (rst) begin
      m_lock = 0; m_sw = 1; m_sec = 0; m_wait = 0; m_tmr = 0;
      m_next = 5'b00000;
    end else begin
      rej = 0; nlock = m_lock; nwait = m_wait;
      ntmr = m_wait ? m_tmr + 1 : 0;
      if (!m_wait) begin
        if (lock_set_req) begin
          nlock = 1; rej = lock_clr_req;
        end else if (lock_clr_req) begin
          if (eff == 2'd0) nlock = 0;
          else if (eff == 2'd1 && lvl0_req) begin nwait = 1; ntmr = 0; end
          else rej = 1;
        end
      end else begin
        if (lock_set_req) begin nlock = 1; nwait = 0; rej = 1; end
        else if (erase_done) begin nlock = 0; nwait = 0; end
        else if (m_tmr == TMO - 1) begin rej = 1; nwait = 0; end
      end
      nsw  = dbg_wr ? dbg_wr_val : m_sw;
      nsec = m_sec | sec_set;
      m_next = {(eff != 2'd2) && nsw, nlock, nsec, rej, nwait};
      m_lock = nlock; m_wait = nwait; m_tmr = ntmr; m_sw = nsw; m_sec = nsec;
    end
    it.tag = tag;
    it.exp = m_next;
    q.push_back(it);
    @(negedge clk);
    lock_set_req = 0; lock_clr_req = 0; erase_done = 0;
    dbg_wr = 0; sec_set = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor: compares outputs one time step after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it = q.pop_front();
        act = {dbg_allow, boot_force_main, sec_locked, clr_reject, erase_req};
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s: {dbg,boot,sec,rej,ereq} actual=%b expected=%b at %0t",
                   it.tag, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R11 reset"); step("R11 reset");
    rst = 0;
    prot_lvl = 2'd0; idle(2, "R2 debug default on");
    dbg_wr = 1; dbg_wr_val = 0; step("R2 write 0");
    idle(1, "R2 hold off");
    dbg_wr = 1; dbg_wr_val = 1; step("R2 write 1");
    prot_lvl = 2'd2; idle(2, "R1 level 2 forces off");
    prot_lvl = 2'd3; idle(1, "R3 code 3 as level 1 debug");

    prot_lvl = 2'd2; lock_set_req = 1; step("R4 set at level 2");
    lock_clr_req = 1; step("R7 clear at level 2 rejected");
    idle(1, "R7 reject one cycle");
    prot_lvl = 2'd1; lvl0_req = 0; lock_clr_req = 1; step("R7 clear level 1 no lvl0");
    lvl0_req = 1; lock_clr_req = 1; step("R7 clear during wait ignored setup");
    lock_clr_req = 1; step("R7 clear while pending ignored");
    idle(2, "R6 waiting for erase");
    erase_done = 1; step("R6 erase completes clear");
    idle(1, "R6 after clear");

    prot_lvl = 2'd3; lock_set_req = 1; step("R4 set again");
    lock_clr_req = 1; step("R3 code 3 qualifies clear");
    erase_done = 1; step("R3 R6 clear via code 3");

    prot_lvl = 2'd1; lock_set_req = 1; step("R4 set");
    lock_clr_req = 1; step("R8 start clear");
    idle(TMO + 2, "R8 timeout reject");

    lock_clr_req = 1; step("R9 start clear");
    idle(3, "R9 pending");
    lock_set_req = 1; erase_done = 1; step("R9 set with erase_done");
    idle(1, "R9 after");
    prot_lvl = 2'd0; lock_set_req = 1; lock_clr_req = 1; step("R9 set and clear together");
    idle(1, "R9 lock kept");
    lock_clr_req = 1; step("R5 clear at level 0");
    idle(1, "R5 stays clear");

    sec_set = 1; step("R10 sec set");
    idle(3, "R10 sticky");
    dbg_wr = 1; dbg_wr_val = 0; step("R10 unrelated write");
    idle(1, "R10 still set");
    rst = 1; step("R11 reset clears all"); rst = 0;
    idle(2, "R11 R10 after reset");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule